// File: doc/BRIEF.md
# Write-Back Eviction Controller with Posted Line Buffer

This block sits between a write-back cache and a single memory port and decides when modified lines reach memory. A write that hits in the cache only marks the slot as modified. When a miss replaces a modified line, the old line is parked in a small first-in first-out buffer, the refill read goes to memory first, and the parked lines are written out later, once the memory port has no read to serve.

The cache side offers two operations, each with a valid/ready handshake: a write hit (slot, line address, new line contents) and a miss (slot, new line address, outgoing line address and contents). The block keeps one modified flag per cache slot and answers each miss with a one-cycle refill pulse. If a miss asks for a line that is still parked, the refill is taken from the buffer and no read is issued. A write-through mode input sends every write hit straight to memory and leaves the slot unmodified. The memory side has separate read and write request/acknowledge channels.

Top module: `wbe_evict_ctrl`

## Requirements
- R1: In write-back mode (wt_mode = 0) an accepted write hit marks its slot as modified and raises no memory write in the following cycle. The write hit is accepted in a single cycle.
- R2: A miss whose slot is marked as modified causes exactly one memory write carrying the outgoing line address and contents.
- R3: A miss whose slot is not marked as modified causes no memory write.
- R4: For a miss that evicts a modified line, the refill read of the new address is acknowledged before that line's write-back. The refill pulse carries the read data with fill_fwd = 0.
- R5: mem_rd_req and mem_wr_req are never high together. A background drain of the buffer starts only from idle, when neither miss_valid nor hit_wr_valid was high in the preceding cycle.
- R6: The buffer absorbs DEPTH modified evictions in a row without any memory write.
- R7: With wt_mode = 1 an accepted write hit issues a memory write of its address and contents. The cache side is stalled until that write is acknowledged, and the slot stays unmodified. Any older parked lines are written first.
- R8: A miss whose new address equals a parked line's address gets a refill pulse with fill_fwd = 1 and the newest parked contents for that address, and no memory read is issued.
- R9: A modified eviction that finds the buffer full first writes the oldest parked line to memory, even if the refill read is waiting. The cache side is held not-ready throughout. The buffer never holds more than DEPTH lines.
- R10: Parked lines reach memory in the order they were evicted.
- R11: A refill clears the slot's modified flag, so the next miss on that slot writes nothing unless a new write hit intervenes.
- R12: A memory read or write request, once raised, stays high with a stable address until it is acknowledged.
- R13: During and after reset, with no operation presented: no memory request is raised, both cache-side ready outputs are high and fill_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back |
| hit_wr_valid | input | 1 | Write hit presented |
| hit_wr_ready | output | 1 | Write hit accepted this cycle |
| hit_wr_slot | input | SLOT_W | Cache slot written |
| hit_wr_addr | input | ADDR_W | Line address of the write |
| hit_wr_data | input | LINE_W | Updated line contents |
| miss_valid | input | 1 | Miss presented |
| miss_ready | output | 1 | Miss accepted this cycle |
| miss_slot | input | SLOT_W | Slot being replaced |
| miss_addr | input | ADDR_W | Line address to fetch |
| victim_addr | input | ADDR_W | Line address now held in the slot |
| victim_data | input | LINE_W | Contents now held in the slot |
| fill_valid | output | 1 | One-cycle refill pulse |
| fill_fwd | output | 1 | Refill taken from the buffer |
| fill_data | output | LINE_W | Refill line contents |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read line address |
| mem_rd_ack | input | 1 | Read completes this cycle |
| mem_rd_data | input | LINE_W | Read line contents |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Memory write line address |
| mem_wr_data | output | LINE_W | Memory write line contents |
| mem_wr_ack | input | 1 | Write completes this cycle |

## Verification
The bench keeps operations back to back so that no idle drain can start. This lets it fill the buffer to its depth, then push one more modified eviction. A design that dropped the entry or overwrote one would lose or reorder a write-back, and a design that served the refill first would issue the read before the forced write. A miss aimed at a parked address catches a design without forwarding, which would issue an unexpected read. A write-through write behind parked lines catches a design that writes straight past older data. Repeated misses on one slot catch a modified flag that is never cleared, which would produce an extra write-back.

// File: rtl/wbe_pkg.sv
`timescale 1ns/1ps
package wbe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_FORCE,
    ST_READ,
    ST_DRAIN,
    ST_WT
  } wbe_state_e;

  // circular index arithmetic shared by the buffer
  function automatic int wrap_add(input int base, input int step, input int modulus);
    return (base + step) % modulus;
  endfunction

endpackage

// File: rtl/wbe_dirty_bits.sv
`timescale 1ns/1ps
module wbe_dirty_bits #(
  parameter int SLOTS = 16,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_dirty
);

  logic [SLOTS-1:0] flag_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flag_q[g] <= 1'b0;
      else if (set_en && set_slot == SLOT_W'(g))
        flag_q[g] <= 1'b1;
      else if (clr_en && clr_slot == SLOT_W'(g))
        flag_q[g] <= 1'b0;
    end
  end

  assign rd_dirty = flag_q[rd_slot];

endmodule

// File: rtl/wbe_post_fifo.sv
`timescale 1ns/1ps
module wbe_post_fifo
  import wbe_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 20,
  parameter int LINE_W = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [LINE_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [LINE_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [LINE_W-1:0] look_data
);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  count_q;
  logic [PTR_W-1:0]  tail;

  assign tail      = PTR_W'(wrap_add(int'(head_q), int'(count_q), DEPTH));
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign count     = count_q;
  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail] <= push_addr;
      data_q[tail] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop)
        head_q <= PTR_W'(wrap_add(int'(head_q), 1, DEPTH));
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // scan from oldest to newest; the newest match wins
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(count_q) &&
          addr_q[PTR_W'(wrap_add(int'(head_q), i, DEPTH))] == look_addr) begin
        look_hit  = 1'b1;
        look_data = data_q[PTR_W'(wrap_add(int'(head_q), i, DEPTH))];
      end
    end
  end

endmodule

// File: rtl/wbe_evict_ctrl.sv
`timescale 1ns/1ps
module wbe_evict_ctrl
  import wbe_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LINE_W = 64,
  parameter int DEPTH  = 4,
  parameter int SLOTS  = 16,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wt_mode,
  input  logic              hit_wr_valid,
  output logic              hit_wr_ready,
  input  logic [SLOT_W-1:0] hit_wr_slot,
  input  logic [ADDR_W-1:0] hit_wr_addr,
  input  logic [LINE_W-1:0] hit_wr_data,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [SLOT_W-1:0] miss_slot,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [ADDR_W-1:0] victim_addr,
  input  logic [LINE_W-1:0] victim_data,
  output logic              fill_valid,
  output logic              fill_fwd,
  output logic [LINE_W-1:0] fill_data,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [LINE_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  wbe_state_e st_q;

  logic [ADDR_W-1:0] m_addr_q, v_addr_q, w_addr_q;
  logic [SLOT_W-1:0] m_slot_q;
  logic [LINE_W-1:0] v_data_q, w_data_q, fill_data_q;
  logic              v_dirty_q, fill_valid_q, fill_fwd_q;

  // named internal events
  logic acc_miss, acc_wr, victim_dirty;
  logic ev_push, ev_pop, ev_evict_stall, ev_refill, ev_fwd_hit;
  logic ev_force_drain, in_drain, wr_from_buf;

  logic [ADDR_W-1:0] head_addr;
  logic [LINE_W-1:0] head_data, look_data;
  logic [CNT_W-1:0]  buf_count;
  logic              buf_full, buf_empty, look_hit;

  assign miss_ready   = (st_q == ST_IDLE);
  assign hit_wr_ready = (st_q == ST_IDLE) && !miss_valid;
  assign acc_miss     = miss_valid && miss_ready;
  assign acc_wr       = hit_wr_valid && hit_wr_ready;

  assign ev_evict_stall = (st_q == ST_EVAL) && v_dirty_q && buf_full;
  assign ev_push        = (st_q == ST_EVAL) && v_dirty_q && !buf_full;
  assign ev_refill      = (st_q == ST_EVAL) && !ev_evict_stall;
  assign ev_fwd_hit     = ev_refill && look_hit;
  assign ev_force_drain = (st_q == ST_FORCE);
  assign in_drain       = (st_q == ST_DRAIN);
  assign wr_from_buf    = ev_force_drain || in_drain || (st_q == ST_WT && !buf_empty);
  assign ev_pop         = wr_from_buf && mem_wr_ack;

  assign mem_rd_req  = (st_q == ST_READ);
  assign mem_rd_addr = m_addr_q;
  assign mem_wr_req  = ev_force_drain || in_drain || (st_q == ST_WT);
  assign mem_wr_addr = wr_from_buf ? head_addr : w_addr_q;
  assign mem_wr_data = wr_from_buf ? head_data : w_data_q;

  assign fill_valid = fill_valid_q;
  assign fill_fwd   = fill_fwd_q;
  assign fill_data  = fill_data_q;

  wbe_dirty_bits #(.SLOTS(SLOTS)) u_dirty (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (acc_wr && !wt_mode),
    .set_slot (hit_wr_slot),
    .clr_en   (ev_refill || (acc_wr && wt_mode)),
    .clr_slot (ev_refill ? m_slot_q : hit_wr_slot),
    .rd_slot  (miss_slot),
    .rd_dirty (victim_dirty)
  );

  wbe_post_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .push_addr (v_addr_q),
    .push_data (v_data_q),
    .pop       (ev_pop),
    .head_addr (head_addr),
    .head_data (head_data),
    .count     (buf_count),
    .full      (buf_full),
    .empty     (buf_empty),
    .look_addr (m_addr_q),
    .look_hit  (look_hit),
    .look_data (look_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      m_addr_q     <= '0;
      m_slot_q     <= '0;
      v_addr_q     <= '0;
      v_data_q     <= '0;
      v_dirty_q    <= 1'b0;
      w_addr_q     <= '0;
      w_data_q     <= '0;
      fill_valid_q <= 1'b0;
      fill_fwd_q   <= 1'b0;
      fill_data_q  <= '0;
    end else begin
      fill_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (acc_miss) begin
            m_addr_q  <= miss_addr;
            m_slot_q  <= miss_slot;
            v_addr_q  <= victim_addr;
            v_data_q  <= victim_data;
            v_dirty_q <= victim_dirty;
            st_q      <= ST_EVAL;
          end else if (acc_wr && wt_mode) begin
            w_addr_q <= hit_wr_addr;
            w_data_q <= hit_wr_data;
            st_q     <= ST_WT;
          end else if (!hit_wr_valid && !buf_empty) begin
            st_q <= ST_DRAIN;
          end
        end
        ST_EVAL: begin
          if (ev_evict_stall) begin
            st_q <= ST_FORCE;
          end else if (look_hit) begin
            fill_valid_q <= 1'b1;
            fill_fwd_q   <= 1'b1;
            fill_data_q  <= look_data;
            st_q         <= ST_IDLE;
          end else begin
            st_q <= ST_READ;
          end
        end
        ST_FORCE: if (mem_wr_ack) st_q <= ST_EVAL;
        ST_READ: begin
          if (mem_rd_ack) begin
            fill_valid_q <= 1'b1;
            fill_fwd_q   <= 1'b0;
            fill_data_q  <= mem_rd_data;
            st_q         <= ST_IDLE;
          end
        end
        ST_DRAIN: if (mem_wr_ack) st_q <= ST_IDLE;
        ST_WT:    if (mem_wr_ack && !wr_from_buf) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wbe_evict_checker.sv
`timescale 1ns/1ps
module wbe_evict_checker #(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wt_mode,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              hit_wr_valid,
  input logic              hit_wr_ready,
  input logic              mem_rd_req,
  input logic              mem_rd_ack,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_req,
  input logic              mem_wr_ack,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [CNT_W-1:0]  buf_count,
  input logic              ev_fwd_hit,
  input logic              ev_force_drain,
  input logic              in_drain
);

  assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  assert_drain_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_drain) |-> $past(!miss_valid && !hit_wr_valid));

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count <= CNT_W'(DEPTH));

  assert_force_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_force_drain |-> (!miss_ready && !hit_wr_ready && mem_wr_req));

  assert_fwd_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fwd_hit |=> !mem_rd_req);

  assert_wb_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr_valid && hit_wr_ready && !wt_mode) |=> !mem_wr_req);

  assert_wt_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr_valid && hit_wr_ready && wt_mode) |=> (mem_wr_req && !hit_wr_ready));

endmodule

bind wbe_evict_ctrl wbe_evict_checker #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wt_mode        (wt_mode),
  .miss_valid     (miss_valid),
  .miss_ready     (miss_ready),
  .hit_wr_valid   (hit_wr_valid),
  .hit_wr_ready   (hit_wr_ready),
  .mem_rd_req     (mem_rd_req),
  .mem_rd_ack     (mem_rd_ack),
  .mem_rd_addr    (mem_rd_addr),
  .mem_wr_req     (mem_wr_req),
  .mem_wr_ack     (mem_wr_ack),
  .mem_wr_addr    (mem_wr_addr),
  .buf_count      (buf_count),
  .ev_fwd_hit     (ev_fwd_hit),
  .ev_force_drain (ev_force_drain),
  .in_drain       (in_drain)
);

// File: tb/wbe_evict_ctrl_test.sv
`timescale 1ns/1ps
module wbe_evict_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int LINE_W = 64;
  localparam int DEPTH  = 4;
  localparam int SLOTS  = 16;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int RD_LAT = 3;
  localparam int WR_LAT = 2;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_mode = 1'b0;
  logic hit_wr_valid = 1'b0, hit_wr_ready;
  logic [SLOT_W-1:0] hit_wr_slot = '0;
  logic [ADDR_W-1:0] hit_wr_addr = '0;
  logic [LINE_W-1:0] hit_wr_data = '0;
  logic miss_valid = 1'b0, miss_ready;
  logic [SLOT_W-1:0] miss_slot = '0;
  logic [ADDR_W-1:0] miss_addr = '0, victim_addr = '0;
  logic [LINE_W-1:0] victim_data = '0;
  logic fill_valid, fill_fwd;
  logic [LINE_W-1:0] fill_data;
  logic mem_rd_req, mem_wr_req;
  logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
  logic [LINE_W-1:0] mem_wr_data;
  logic mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
  logic [LINE_W-1:0] mem_rd_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbe_evict_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .DEPTH(DEPTH), .SLOTS(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode),
    .hit_wr_valid(hit_wr_valid), .hit_wr_ready(hit_wr_ready), .hit_wr_slot(hit_wr_slot),
    .hit_wr_addr(hit_wr_addr), .hit_wr_data(hit_wr_data),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_slot(miss_slot),
    .miss_addr(miss_addr), .victim_addr(victim_addr), .victim_data(victim_data),
    .fill_valid(fill_valid), .fill_fwd(fill_fwd), .fill_data(fill_data),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack)
  );

  int checks = 0, fails = 0;
  int cyc = 0, wr_done = 0, fills_done = 0, overlap = 0;
  int last_rd_t = 0, last_wr_t = 0, forced_seen = 0, burst_fill_base = 0;
  bit finished = 1'b0;

  logic [ADDR_W+LINE_W-1:0] exp_wr[$];
  logic [ADDR_W-1:0]        exp_rd[$];
  logic [LINE_W:0]          exp_fill[$];

  function automatic logic [LINE_W-1:0] mem_line(input logic [ADDR_W-1:0] a);
    return {12'hA5C, a, 12'h3B1, ~a};
  endfunction

  function automatic logic [LINE_W-1:0] pat(input int k);
    return {32'(k) * 32'h9E3779B1, 32'hC0DE0000 | 32'(k)};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: each task queues what the scoreboard must see, then drives the op
  task automatic do_write(input int s, input logic [ADDR_W-1:0] a,
                          input logic [LINE_W-1:0] d);
    if (wt_mode) exp_wr.push_back({a, d});
    hit_wr_slot = SLOT_W'(s); hit_wr_addr = a; hit_wr_data = d; hit_wr_valid = 1'b1;
    forever begin
      #1;
      if (hit_wr_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    hit_wr_valid = 1'b0;
  endtask

  task automatic do_miss(input int s, input logic [ADDR_W-1:0] a,
                         input logic [ADDR_W-1:0] va, input logic [LINE_W-1:0] vd,
                         input bit dirty, input bit fwd, input logic [LINE_W-1:0] fd);
    if (dirty) exp_wr.push_back({va, vd});
    if (fwd) exp_fill.push_back({1'b1, fd});
    else begin
      exp_rd.push_back(a);
      exp_fill.push_back({1'b0, mem_line(a)});
    end
    miss_slot = SLOT_W'(s); miss_addr = a; victim_addr = va; victim_data = vd;
    miss_valid = 1'b1;
    forever begin
      #1;
      if (miss_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  // memory model and monitor
  initial begin
    int rd_cnt = 0, wr_cnt = 0;
    logic [ADDR_W-1:0] rd_first = '0, wr_first = '0;
    logic [ADDR_W+LINE_W-1:0] ew;
    logic [LINE_W:0] ef;
    logic [ADDR_W-1:0] er;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (mem_rd_req && mem_wr_req) overlap++;
        if (mem_rd_ack) mem_rd_ack = 1'b0;
        else if (mem_rd_req) begin
          if (rd_cnt == 0) rd_first = mem_rd_addr;
          rd_cnt++;
          if (rd_cnt >= RD_LAT) begin
            rd_cnt = 0;
            check(mem_rd_addr == rd_first, "R12 read address held", mem_rd_addr, rd_first);
            mem_rd_ack = 1'b1;
            mem_rd_data = mem_line(mem_rd_addr);
            last_rd_t = cyc;
            if (exp_rd.size() == 0)
              check(1'b0, "R8 unexpected read", mem_rd_addr, 0);
            else begin
              er = exp_rd.pop_front();
              check(mem_rd_addr == er, "R4 refill read address", mem_rd_addr, er);
            end
          end
        end
        if (mem_wr_ack) mem_wr_ack = 1'b0;
        else if (mem_wr_req) begin
          if (wr_cnt == 0) wr_first = mem_wr_addr;
          wr_cnt++;
          if (wr_cnt >= WR_LAT) begin
            wr_cnt = 0;
            check(mem_wr_addr == wr_first, "R12 write address held", mem_wr_addr, wr_first);
            mem_wr_ack = 1'b1;
            last_wr_t = cyc;
            wr_done++;
            if (miss_valid) begin
              check(!miss_ready, "R9 cache stalled during forced drain", miss_ready, 0);
              if (forced_seen == 0)
                check(fills_done == burst_fill_base + DEPTH, "R6 buffer absorbs DEPTH evictions",
                      fills_done, burst_fill_base + DEPTH);
              forced_seen++;
            end
            if (exp_wr.size() == 0)
              check(1'b0, "R3 unexpected write", {mem_wr_addr, mem_wr_data}, 0);
            else begin
              ew = exp_wr.pop_front();
              check({mem_wr_addr, mem_wr_data} == ew, "R10 write order and contents",
                    {mem_wr_addr, mem_wr_data}, ew);
            end
          end
        end
        if (fill_valid) begin
          fills_done++;
          if (exp_fill.size() == 0)
            check(1'b0, "R4 unexpected fill", {fill_fwd, fill_data}, 0);
          else begin
            ef = exp_fill.pop_front();
            check({fill_fwd, fill_data} == ef, ef[LINE_W] ? "R8 forwarded fill" : "R4 refill data",
                  {fill_fwd, fill_data}, ef);
          end
        end
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int wb;
    repeat (3) @(negedge clk);
    // R13: reset state
    check(!mem_rd_req, "R13 no read in reset", mem_rd_req, 0);
    check(!mem_wr_req, "R13 no write in reset", mem_wr_req, 0);
    check(!fill_valid, "R13 no fill in reset", fill_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(miss_ready && hit_wr_ready, "R13 ready after reset", {miss_ready, hit_wr_ready}, 2'b11);
    check(!mem_rd_req && !mem_wr_req, "R13 idle after reset", {mem_rd_req, mem_wr_req}, 0);

    // R3: clean victim, plain refill
    do_miss(0, 20'h00100, 20'h000AA, pat(1), 1'b0, 1'b0, '0);
    repeat (10) @(negedge clk);
    check(wr_done == 0, "R3 clean victim no write", wr_done, 0);

    // R1: write-back hit only marks the slot
    do_write(0, 20'h00100, pat(2));
    repeat (20) @(negedge clk);
    check(wr_done == 0, "R1 write hit held in cache", wr_done, 0);

    // R2/R4: dirty eviction, read goes first
    do_miss(0, 20'h00200, 20'h00100, pat(2), 1'b1, 1'b0, '0);
    repeat (30) @(negedge clk);
    check(wr_done == 1, "R2 dirty victim written once", wr_done, 1);
    check(last_rd_t < last_wr_t, "R4 read before write-back", last_rd_t, last_wr_t);

    // R11: refill cleared the flag
    do_miss(0, 20'h00300, 20'h00200, pat(3), 1'b0, 1'b0, '0);
    repeat (20) @(negedge clk);
    check(wr_done == 1, "R11 refilled slot is clean", wr_done, 1);

    // back-to-back burst: fill buffer, force a drain, forward, write-through
    wb = wr_done;
    burst_fill_base = fills_done;
    for (int i = 1; i <= 5; i++) do_write(i, ADDR_W'(32'h1000 + i), pat(10 + i));
    for (int i = 1; i <= 5; i++)
      do_miss(i, ADDR_W'(32'h2000 + i), ADDR_W'(32'h1000 + i), pat(10 + i), 1'b1, 1'b0, '0);
    do_miss(6, 20'h01003, 20'h00777, pat(40), 1'b0, 1'b1, pat(13));
    wt_mode = 1'b1;
    do_write(7, 20'h03007, pat(50));
    repeat (40) @(negedge clk);
    check(wr_done == wb + 6, "R7 buffered lines then write-through write", wr_done, wb + 6);
    check(forced_seen == 1, "R9 one forced drain", forced_seen, 1);

    // R7: write-through left the slot clean
    do_miss(7, 20'h04007, 20'h03007, pat(50), 1'b0, 1'b0, '0);
    repeat (20) @(negedge clk);
    check(wr_done == wb + 6, "R7 write-through slot clean", wr_done, wb + 6);
    wt_mode = 1'b0;

    check(exp_wr.size() == 0, "R2 all write-backs seen", exp_wr.size(), 0);
    check(exp_rd.size() == 0, "R4 all refill reads seen", exp_rd.size(), 0);
    check(exp_fill.size() == 0, "R8 all fills seen", exp_fill.size(), 0);
    check(overlap == 0, "R5 read and write never together", overlap, 0);
    finish_run();
  end

endmodule